// File: doc/BRIEF.md
# Nibble-Addressed Sample Playback Fetcher

This block places one sample memory between two users that see it with different geometries. A host port reads and writes the storage one byte at a time, using a byte address. A playback engine treats the same storage as a flat array of 4-bit samples, using an address one bit wider. Software writes the sample data through the host port. It then issues a start command carrying a start address in nibbles and a length in bytes. Each sample strobe from the playback side returns the next nibble one cycle later and advances the pointer.

Playback may begin on any nibble, including the upper half of a byte. Each byte of programmed length yields two samples. When the last sample has been delivered, the block drops its busy flag and raises an end flag. Any strobe after that returns a zero nibble. The storage size is a parameter: with `BYTE_AW` = 16 the host sees 64K bytes and playback sees 131,072 nibbles. The default is kept small.

Top module: `nibble_fetch_top`

## Requirements
- R1: After reset `busy`, `end_flag` and `smp_valid` are 0 and `smp_data` is 0.
- R2: A host write (`host_en`=1, `host_we`=1) stores `host_wdata` at byte `host_addr`. A host read (`host_en`=1, `host_we`=0) presents that byte on `host_rdata` in the cycle after the request.
- R3: Nibble address n maps to byte n>>1. Bit 0 of n equal to 0 selects bits [3:0] of that byte, and 1 selects bits [7:4]. Successive strobes deliver ascending nibble addresses, so the low half of a byte comes before its high half.
- R4: A start on an odd nibble address delivers the high half of the first byte first, then continues with the next byte's low half.
- R5: A start with length L>0 delivers exactly 2·L samples. `busy` falls and `end_flag` rises in the same cycle in which the last sample is valid. `end_flag` stays high until the next accepted start, and it is never high together with `busy`.
- R6: Each strobe sets `smp_valid` for exactly the following cycle. A strobe taken while not busy returns `smp_data` = 0 and does not change `busy` or `end_flag`.
- R7: The nibble pointer wraps from its top value (2^(BYTE_AW+1)−1) to 0.
- R8: A host write to the byte that a strobe fetches in the same cycle takes effect first: the delivered nibble comes from the newly written data.
- R9: A start command while `busy` is 1 is ignored. The running playback continues with its original address and count.
- R10: A start with length 0 raises `end_flag` in the next cycle and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | BYTE_AW | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after request |
| cmd_start | input | 1 | Start command, accepted when idle |
| cfg_start_nib | input | BYTE_AW+1 | Start address in nibbles |
| cfg_len_bytes | input | BYTE_AW | Length in bytes (two samples each) |
| smp_strobe | input | 1 | Sample request |
| smp_valid | output | 1 | Sample present, one cycle after strobe |
| smp_data | output | 4 | Fetched nibble, 0 when idle |
| busy | output | 1 | Playback running |
| end_flag | output | 1 | Programmed samples consumed |

## Verification
The bench starts playback on both even and odd nibbles. A design that ignored bit 0, or swapped the halves, would deliver wrong or duplicated nibbles. It also runs a sequence across the top of memory, where a design that does not wrap would return data from a wrong or out-of-range address. It writes the byte being fetched in the same cycle as the strobe, where a read-before-write memory would return stale data. It checks the exact count of samples, so an off-by-one counter would end a sample early or late. Finally it issues a second start mid-run and a zero-length start, where a design that reloads while busy would jump address, and a design that treats zero as full length would start a long run.

// File: rtl/nf_pkg.sv
package nf_pkg;
    typedef logic [3:0] nib_t;

    // Low half for even nibble addresses, high half for odd.
    function automatic nib_t pick_nib(input logic [7:0] b, input logic hi);
        return hi ? b[7:4] : b[3:0];
    endfunction
endpackage

// File: rtl/nf_ram.sv
module nf_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    output logic [7:0]    a_q,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    output logic [7:0]    b_q
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Write-first on both read ports: a same-cycle write wins.
    always_ff @(posedge clk) begin
        if (a_en) a_q <= (we && waddr == a_addr) ? wdata : mem[a_addr];
        if (b_en) b_q <= (we && waddr == b_addr) ? wdata : mem[b_addr];
    end
endmodule

// File: rtl/nf_fetch_ctrl.sv
module nf_fetch_ctrl #(
    parameter int BYTE_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [BYTE_AW:0]   cfg_start_nib,
    input  logic [BYTE_AW-1:0] cfg_len_bytes,
    input  logic               smp_strobe,
    output logic               rd_en,
    output logic [BYTE_AW-1:0] rd_addr,
    output logic               out_vld,
    output logic               out_live,
    output logic               out_half,
    output logic               busy,
    output logic               end_flag
);
    localparam int NIB_AW = BYTE_AW + 1;
    localparam int CNT_W  = BYTE_AW + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              vld;
        logic              live;
        logic              half;
        logic [NIB_AW-1:0] ptr;
        logic [CNT_W-1:0]  left;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  take;

    assign take = smp_strobe && st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = smp_strobe;
        st_d.live = take;
        if (take) begin
            st_d.half = st_q.ptr[0];
            st_d.ptr  = st_q.ptr + 1'b1;
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (cmd_start && !st_q.busy) begin
            st_d.ptr  = cfg_start_nib;
            st_d.left = {cfg_len_bytes, 1'b0};
            st_d.busy = (cfg_len_bytes != '0);
            st_d.done = (cfg_len_bytes == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_en    = take;
    assign rd_addr  = st_q.ptr[NIB_AW-1:1];
    assign out_vld  = st_q.vld;
    assign out_live = st_q.live;
    assign out_half = st_q.half;
    assign busy     = st_q.busy;
    assign end_flag = st_q.done;
endmodule

// File: rtl/nibble_fetch_top.sv
module nibble_fetch_top #(
    parameter int BYTE_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [BYTE_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               cmd_start,
    input  logic [BYTE_AW:0]   cfg_start_nib,
    input  logic [BYTE_AW-1:0] cfg_len_bytes,
    input  logic               smp_strobe,
    output logic               smp_valid,
    output logic [3:0]         smp_data,
    output logic               busy,
    output logic               end_flag
);
    import nf_pkg::*;

    logic               rd_en, out_vld, out_live, out_half;
    logic [BYTE_AW-1:0] rd_addr;
    logic [7:0]         fetch_q;

    nf_fetch_ctrl #(.BYTE_AW(BYTE_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cfg_start_nib(cfg_start_nib),
        .cfg_len_bytes(cfg_len_bytes), .smp_strobe(smp_strobe),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .out_vld(out_vld), .out_live(out_live), .out_half(out_half),
        .busy(busy), .end_flag(end_flag)
    );

    nf_ram #(.AW(BYTE_AW)) u_ram (
        .clk(clk),
        .we(host_en && host_we), .waddr(host_addr), .wdata(host_wdata),
        .a_en(host_en && !host_we), .a_addr(host_addr), .a_q(host_rdata),
        .b_en(rd_en), .b_addr(rd_addr), .b_q(fetch_q)
    );

    assign smp_valid = out_vld;
    assign smp_data  = (out_vld && out_live) ? pick_nib(fetch_q, out_half) : 4'h0;
endmodule

// File: rtl/nf_checker.sv
module nf_checker #(
    parameter int BYTE_AW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_start,
    input logic [BYTE_AW-1:0] cfg_len_bytes,
    input logic               smp_strobe,
    input logic               smp_valid,
    input logic [3:0]         smp_data,
    input logic               busy,
    input logic               end_flag
);
    assert_end_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        end_flag |-> !busy);

    assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_strobe |=> smp_valid);

    assert_no_valid_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_strobe |=> !smp_valid);

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe && !busy) |=> (smp_data == 4'h0 && $stable(end_flag) && !busy));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start && !smp_strobe) |=> busy);

    assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && cfg_len_bytes == '0) |=> (end_flag && !busy));
endmodule

bind nibble_fetch_top nf_checker #(.BYTE_AW(BYTE_AW)) u_nf_checker (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
    .cfg_len_bytes(cfg_len_bytes), .smp_strobe(smp_strobe),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .busy(busy), .end_flag(end_flag)
);

// File: tb/nibble_fetch_top_test.sv
`timescale 1ns/1ps
module nibble_fetch_top_test;
    localparam int BAW  = 10;
    localparam int NB   = 1 << BAW;
    localparam int NTOP = (2 * NB) - 1;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           host_en = 0, host_we = 0;
    logic [BAW-1:0] host_addr = '0;
    logic [7:0]     host_wdata = '0;
    logic [7:0]     host_rdata;
    logic           cmd_start = 0;
    logic [BAW:0]   cfg_start_nib = '0;
    logic [BAW-1:0] cfg_len_bytes = '0;
    logic           smp_strobe = 0;
    logic           smp_valid;
    logic [3:0]     smp_data;
    logic           busy, end_flag;

    int checks = 0, fails = 0;
    logic [7:0] ref_mem [NB];

    always #2 clk = ~clk;

    nibble_fetch_top #(.BYTE_AW(BAW)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_nib(input int n);
        logic [7:0] b;
        b = ref_mem[(n & NTOP) >> 1];
        return n[0] ? b[7:4] : b[3:0];
    endfunction

    task automatic hwrite(input int a, input logic [7:0] d);
        @(negedge clk);
        host_en = 1; host_we = 1; host_addr = BAW'(a); host_wdata = d;
        ref_mem[a] = d;
        @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    task automatic start(input int nib, input int len);
        @(negedge clk);
        cmd_start = 1; cfg_start_nib = (BAW+1)'(nib); cfg_len_bytes = BAW'(len);
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic strobe_chk(input string req, input logic [3:0] exp,
                              input logic exp_busy, input logic exp_end);
        @(negedge clk);
        smp_strobe = 1;
        @(negedge clk);
        smp_strobe = 0;
        chk(req, smp_valid, 1'b1);
        chk(req, smp_data, exp);
        chk(req, busy, exp_busy);
        chk(req, end_flag, exp_end);
    endtask

    task automatic play(input string req, input int nib, input int len);
        start(nib, len);
        chk(req, busy, 1'b1);
        for (int i = 0; i < 2 * len; i++)
            strobe_chk(req, exp_nib(nib + i), i != 2 * len - 1, i == 2 * len - 1);
        strobe_chk("R6", 4'h0, 1'b0, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1", busy, 1'b0);
        chk("R1", end_flag, 1'b0);
        chk("R1", smp_valid, 1'b0);
        chk("R1", smp_data, 4'h0);
    endtask

    task automatic t_host_rw;
        hwrite(5, 8'hA7);
        @(negedge clk);
        host_en = 1; host_we = 0; host_addr = BAW'(5);
        @(negedge clk);
        host_en = 0;
        chk("R2", host_rdata, 8'hA7);
    endtask

    task automatic t_idle_strobe;
        strobe_chk("R6", 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6", smp_valid, 1'b0);
    endtask

    task automatic t_even;
        for (int i = 0; i < 3; i++) hwrite(8 + i, 8'h21 + 8'(i * 8'h44));
        play("R3", 16, 3);
    endtask

    task automatic t_odd;
        hwrite(20, 8'h9C); hwrite(21, 8'h5E); hwrite(22, 8'hB3);
        play("R4", 41, 2);
    endtask

    task automatic t_wrap;
        hwrite(NB - 1, 8'hD4); hwrite(0, 8'h6F);
        play("R7", NTOP - 1, 2);
    endtask

    task automatic t_collide;
        hwrite(30, 8'h11);
        start(60, 1);
        @(negedge clk);
        smp_strobe = 1;
        host_en = 1; host_we = 1; host_addr = BAW'(30); host_wdata = 8'hE8;
        ref_mem[30] = 8'hE8;
        @(negedge clk);
        smp_strobe = 0; host_en = 0; host_we = 0;
        chk("R8", smp_data, 4'h8);
        strobe_chk("R8", 4'hE, 1'b0, 1'b1);
    endtask

    task automatic t_busy_ignore;
        hwrite(40, 8'h73); hwrite(41, 8'hC2);
        start(80, 2);
        strobe_chk("R9", 4'h3, 1'b1, 1'b0);
        start(100, 7);
        chk("R9", busy, 1'b1);
        strobe_chk("R9", 4'h7, 1'b1, 1'b0);
        strobe_chk("R9", 4'h2, 1'b1, 1'b0);
        strobe_chk("R9", 4'hC, 1'b0, 1'b1);
        strobe_chk("R9", 4'h0, 1'b0, 1'b1);
    endtask

    task automatic t_zero_len;
        start(10, 0);
        chk("R10", end_flag, 1'b1);
        chk("R10", busy, 1'b0);
        strobe_chk("R10", 4'h0, 1'b0, 1'b1);
        start(16, 1);
        chk("R5", end_flag, 1'b0);
        strobe_chk("R5", exp_nib(16), 1'b1, 1'b0);
        strobe_chk("R5", exp_nib(17), 1'b0, 1'b1);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'h00;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            host_en = 1; host_we = 1; host_addr = BAW'(i); host_wdata = 8'h00;
        end
        @(negedge clk);
        host_en = 0; host_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_host_rw;
        t_idle_strobe;
        t_even;
        t_odd;
        t_wrap;
        t_collide;
        t_busy_ignore;
        t_zero_len;
        report;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end
endmodule